// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a 64-bit virtual address to a physical page address. It walks a radix page table held in memory, one 64-bit word at a time, through a plain read request and response port. Each of the five levels has its own index bit position and index width. Level 4 is the outermost directory and level 0 holds the leaf entry. A directory level configured with width 0 is bypassed and costs no memory read. A directory word marked as a huge page ends the walk early and is reformatted into a leaf.

A walk starts with a one-cycle `start` pulse. The walker raises `done` for one cycle when it has the result. It then reports whether the leaf is valid, whether it grants write permission, and the page-aligned physical address. Read permission is implied by a valid result. Faults other than valid or invalid, privilege checks and translation-cache fill are handled elsewhere.

Top module: `ptw_walker`

## Requirements
- R1: The walk's starting base is `root_hi` when virtual address bit 63 is 1, and `root_lo` when it is 0. In both cases it is masked to the low PA_W bits.
- R2: Directory levels are visited from 4 down to 1. A level whose width field is 0 produces no memory read.
- R3: Each read address is the current base OR (((va >> pos) & ((1 << width) - 1)) << 3), truncated to PA_W bits. A fetched directory word, masked to PA_W bits, becomes the base for the next read.
- R4: When a masked directory word has bit 6 (huge) set, no further reads follow and that word becomes the leaf. In the leaf, bits 14:13 and bit 6 are cleared. If bit 12 is set, it is cleared and bit 52 (global) is set.
- R5: Without a huge stop, one more read at level 0 fetches the leaf, which is used unmasked.
- R6: The result is valid when leaf bit 0 is set. Writable is set only when the result is valid and leaf bit 1 is set. An invalid result reports paddr 0 and writable 0.
- R7: The paddr is computed as leaf + (va & PA mask & ((1 << pos_last) - 1)), where pos_last is the position of the level that supplied the leaf. Bits 63:61 are then cleared, and then the low PAGE_SHIFT bits are cleared.
- R8: Requests are single-cycle pulses. At most one request is outstanding, and the next request is issued only after `mem_rsp_valid` has been seen.
- R9: `done` is a one-cycle pulse in the cycle after the final response. The result outputs hold their value until the next `done`.
- R10: A `start` pulse that arrives while a walk is in progress is ignored. It changes neither the running walk nor the reads, and it launches no later walk.
- R11: After reset the walker is idle, with `done`, `mem_req_valid`, `valid`, `writable` and `paddr` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk for `vaddr` |
| vaddr | input | 64 | Virtual address to translate |
| root_hi | input | 64 | Root base used when vaddr bit 63 is 1 |
| root_lo | input | 64 | Root base used when vaddr bit 63 is 0 |
| lvl_pos | input | LVLS*LB_W | Index bit position per level, level 0 in the low field |
| lvl_width | input | LVLS*LW_W | Index width per level, level 0 in the low field |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | PA_W | Read address |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 64 | Read data word |
| done | output | 1 | Result pulse |
| valid | output | 1 | Leaf entry valid |
| paddr | output | 64 | Page-aligned physical address |
| writable | output | 1 | Write permission |

## Verification
The hardest path to reach from the ports is a huge stop at an upper level in combination with skipped levels and the global relocation. It requires a directory word with particular flag bits at exactly the level the walk reaches. The bench generates every memory word from a hash of its address and a seed, so the flag bits at each level vary between walks. It then sweeps all sixteen skip patterns of the four directory levels, both roots and several seeds and response latencies. An independent walk model in the bench predicts the read address sequence and the result for each walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int V_POS    = 0;
  localparam int D_POS    = 1;
  localparam int HUGE_POS = 6;
  localparam int HGLB_POS = 12;
  localparam int LVF_LO   = 13;
  localparam int LVF_HI   = 14;
  localparam int G_POS    = 52;
  localparam int TOPA_LO  = 61;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} walk_st_e;

  // byte offset of a directory slot selected by the address
  function automatic logic [63:0] slot_off(input logic [63:0] va,
                                           input logic [5:0] pos,
                                           input logic [4:0] wid);
    logic [63:0] idx;
    idx = (va >> pos) & ((64'd1 << wid) - 64'd1);
    return idx << 3;
  endfunction

  // turn a huge directory word into a leaf entry
  function automatic logic [63:0] huge_leaf(input logic [63:0] w);
    logic [63:0] r;
    r = w;
    r[LVF_HI:LVF_LO] = 2'b00;
    r[HUGE_POS] = 1'b0;
    if (w[HGLB_POS]) begin
      r[HGLB_POS] = 1'b0;
      r[G_POS] = 1'b1;
    end
    return r;
  endfunction

  // physical page address from a leaf and the in-page offset
  function automatic logic [63:0] leaf_pa(input logic [63:0] pte,
                                          input logic [63:0] va,
                                          input logic [63:0] pa_mask,
                                          input logic [5:0] off_pos,
                                          input int page_shift);
    logic [63:0] s;
    s = pte + (va & pa_mask & ((64'd1 << off_pos) - 64'd1));
    s[63:TOPA_LO] = 3'b000;
    return s & ~((64'd1 << page_shift) - 64'd1);
  endfunction
endpackage

// File: rtl/ptw_next_lvl.sv
module ptw_next_lvl #(
  parameter int LVLS = 5,
  parameter int LW_W = 5,
  localparam int LV_W = $clog2(LVLS)
) (
  input  logic [LVLS*LW_W-1:0] widths,
  input  logic [LV_W-1:0]      from_lvl,
  output logic [LV_W-1:0]      nxt_lvl
);
  logic [LVLS-1:0] cand;

  assign cand[0] = 1'b0;
  for (genvar l = 1; l < LVLS; l++) begin : g_cand
    assign cand[l] = (LV_W'(l) <= from_lvl) && (widths[l*LW_W +: LW_W] != '0);
  end

  // highest eligible directory level, level 0 when none remains
  always_comb begin
    nxt_lvl = '0;
    for (int l = 1; l < LVLS; l++)
      if (cand[l]) nxt_lvl = LV_W'(l);
  end
endmodule

// File: rtl/ptw_leaf_fmt.sv
module ptw_leaf_fmt #(
  parameter int PA_W = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int LB_W = 6
) (
  input  logic [63:0]     word,
  input  logic            is_huge,
  input  logic [63:0]     va,
  input  logic [LB_W-1:0] off_pos,
  output logic            ok,
  output logic            wr,
  output logic [63:0]     pa
);
  import ptw_pkg::*;
  localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;

  logic [63:0] pte;
  assign pte = is_huge ? huge_leaf(word) : word;
  assign ok  = pte[V_POS];
  assign wr  = pte[V_POS] & pte[D_POS];
  assign pa  = pte[V_POS] ? leaf_pa(pte, va, PA_MASK, 6'(off_pos), PAGE_SHIFT) : 64'd0;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int PA_W = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int LVLS = 5,
  parameter int LB_W = 6,
  parameter int LW_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [63:0]          vaddr,
  input  logic [63:0]          root_hi,
  input  logic [63:0]          root_lo,
  input  logic [LVLS*LB_W-1:0] lvl_pos,
  input  logic [LVLS*LW_W-1:0] lvl_width,
  output logic                 mem_req_valid,
  output logic [PA_W-1:0]      mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [63:0]          mem_rsp_data,
  output logic                 done,
  output logic                 valid,
  output logic [63:0]          paddr,
  output logic                 writable
);
  import ptw_pkg::*;
  localparam int LV_W = $clog2(LVLS);
  localparam logic [LV_W-1:0] TOP_LVL = LV_W'(LVLS - 1);
  localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;

  walk_st_e        st;
  logic [63:0]     va_q, base_q;
  logic [LV_W-1:0] lvl_q, from_lvl, nxt_lvl;

  // named events for the checker
  logic            ev_start, ev_leaf, ev_huge, ev_descend;
  logic [63:0]     dir_word, leaf_word, slot_addr, leaf_pa_w;
  logic            at_leaf_lvl, huge_hit, leaf_ok, leaf_wr;
  logic [LB_W-1:0] cur_pos;
  logic [LW_W-1:0] cur_wid;

  assign cur_pos     = lvl_pos[lvl_q*LB_W +: LB_W];
  assign cur_wid     = lvl_width[lvl_q*LW_W +: LW_W];
  assign at_leaf_lvl = (lvl_q == '0);
  assign dir_word    = mem_rsp_data & PA_MASK;
  assign huge_hit    = !at_leaf_lvl && dir_word[HUGE_POS];
  assign leaf_word   = at_leaf_lvl ? mem_rsp_data : dir_word;

  assign ev_start   = (st == ST_IDLE) && start;
  assign ev_leaf    = (st == ST_WAIT) && mem_rsp_valid && (at_leaf_lvl || huge_hit);
  assign ev_huge    = ev_leaf && huge_hit;
  assign ev_descend = (st == ST_WAIT) && mem_rsp_valid && !at_leaf_lvl && !huge_hit;

  assign from_lvl = (st == ST_IDLE) ? TOP_LVL : lvl_q - LV_W'(1);

  ptw_next_lvl #(.LVLS(LVLS), .LW_W(LW_W)) u_next (
    .widths  (lvl_width),
    .from_lvl(from_lvl),
    .nxt_lvl (nxt_lvl)
  );

  ptw_leaf_fmt #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .LB_W(LB_W)) u_leaf (
    .word   (leaf_word),
    .is_huge(huge_hit),
    .va     (va_q),
    .off_pos(cur_pos),
    .ok     (leaf_ok),
    .wr     (leaf_wr),
    .pa     (leaf_pa_w)
  );

  assign slot_addr     = base_q | slot_off(va_q, 6'(cur_pos), 5'(cur_wid));
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_addr  = slot_addr[PA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      va_q     <= '0;
      base_q   <= '0;
      lvl_q    <= '0;
      done     <= 1'b0;
      valid    <= 1'b0;
      paddr    <= '0;
      writable <= 1'b0;
    end else begin
      done <= ev_leaf;
      unique case (st)
        ST_IDLE: if (start) begin
          va_q   <= vaddr;
          base_q <= (vaddr[63] ? root_hi : root_lo) & PA_MASK;
          lvl_q  <= nxt_lvl;
          st     <= ST_REQ;
        end
        ST_REQ: st <= ST_WAIT;
        ST_WAIT: begin
          if (ev_leaf) begin
            valid    <= leaf_ok;
            writable <= leaf_wr;
            paddr    <= leaf_pa_w;
            st       <= ST_IDLE;
          end else if (ev_descend) begin
            base_q <= dir_word;
            lvl_q  <= nxt_lvl;
            st     <= ST_REQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PAGE_SHIFT = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic        valid,
  input logic        writable,
  input logic [63:0] paddr,
  input logic        ev_leaf,
  input logic        ev_huge
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (mem_req_valid) pend <= 1'b1;
    else if (mem_rsp_valid) pend <= 1'b0;
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !pend); // R8
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_LEAF_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf |=> done); // R9
  AST_HUGE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_huge |=> !mem_req_valid); // R4
  AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && writable) |-> valid); // R6
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !valid) |-> (paddr == 64'd0)); // R6
  AST_PADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid) |-> ((paddr[PAGE_SHIFT-1:0] == '0) && (paddr[63:61] == 3'b000))); // R7
endmodule

bind ptw_walker ptw_walker_chk #(.PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req_valid(mem_req_valid),
  .mem_rsp_valid(mem_rsp_valid),
  .done         (done),
  .valid        (valid),
  .writable     (writable),
  .paddr        (paddr),
  .ev_leaf      (ev_leaf),
  .ev_huge      (ev_huge)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam int PA_W = 48;
  localparam logic [63:0] PAM = (64'd1 << PA_W) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] vaddr = '0, root_hi = '0, root_lo = '0;
  logic [29:0] lvl_pos;
  logic [24:0] lvl_width;
  logic mem_req_valid, mem_rsp_valid = 1'b0;
  logic [PA_W-1:0] mem_req_addr;
  logic [63:0] mem_rsp_data = '0;
  logic done, valid, writable;
  logic [63:0] paddr;

  always #2 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
    .root_hi(root_hi), .root_lo(root_lo), .lvl_pos(lvl_pos), .lvl_width(lvl_width),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .valid(valid), .paddr(paddr), .writable(writable)
  );

  int checks = 0, fails = 0;
  int seed = 0, lat = 0, nobs = 0, e_n = 0;
  logic [63:0] obs[8];
  logic [63:0] e_addr[8];
  int p[5] = '{12, 15, 20, 25, 30};
  int w[5];

  function automatic logic [63:0] gen(input logic [63:0] a, input int s);
    logic [63:0] x;
    x = a ^ (64'(s) * 64'h632BE59BD9B4E019);
    x = x * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 31);
    x = x * 64'hBF58476D1CE4E5B9;
    x = x ^ (x >> 29);
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: one response per request after lat+1 negedges
  initial begin
    forever begin
      if (!(rst_n && mem_req_valid)) @(negedge clk);
      else begin
        logic [63:0] a;
        a = 64'(mem_req_addr);
        if (nobs < 8) obs[nobs] = a;
        nobs++;
        repeat (lat + 1) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = gen(a, seed);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // reference walk, written from the requirements
  task automatic model(input logic [63:0] va, output bit ev, output bit ew, output logic [63:0] epa);
    logic [63:0] base, d, pte, a, s, idx;
    bit hg;
    int ob;
    base = (va[63] ? root_hi : root_lo) & PAM;   // R1
    hg = 0; ob = p[0]; pte = '0; e_n = 0;
    for (int l = 4; l >= 1; l--) begin
      if (!hg && w[l] != 0) begin                // R2
        idx = (va >> p[l]) % (64'd1 << w[l]);
        a = (base | (idx * 8)) & PAM;            // R3
        e_addr[e_n] = a; e_n++;
        d = gen(a, seed) & PAM;
        if (d[6]) begin                          // R4
          hg = 1; ob = p[l]; pte = d;
          pte[14:13] = 2'b00; pte[6] = 1'b0;
          if (pte[12]) begin pte[12] = 1'b0; pte[52] = 1'b1; end
        end else base = d;
      end
    end
    if (!hg) begin                               // R5
      idx = (va >> p[0]) % (64'd1 << w[0]);
      a = (base | (idx * 8)) & PAM;
      e_addr[e_n] = a; e_n++;
      pte = gen(a, seed);
    end
    ev = pte[0];
    ew = pte[0] & pte[1];
    if (ev) begin
      s = pte + (va & PAM & ((64'd1 << ob) - 1));
      s = s % (64'd1 << 61);
      epa = s - (s % 64'd4096);
    end else epa = '0;
  endtask

  task automatic walk(input logic [63:0] va, input bit busy_poke);
    bit ev, ew, got;
    logic [63:0] epa;
    model(va, ev, ew, epa);
    nobs = 0;
    @(negedge clk);
    vaddr = va; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busy_poke) begin
      @(negedge clk);
      vaddr = ~va; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 0;
    for (int i = 0; i < 80 && !got; i++) begin
      if (done) got = 1; else @(negedge clk);
    end
    chk(got, "R9 done seen", 64'(got), 64'd1);
    chk(valid == ev, "R6 valid", 64'(valid), 64'(ev));
    chk(writable == ew, "R6 writable", 64'(writable), 64'(ew));
    chk(paddr == epa, "R7 paddr", paddr, epa);
    chk(nobs == e_n, "R2 read count", 64'(nobs), 64'(e_n));
    for (int i = 0; i < e_n && i < nobs; i++)
      chk(obs[i] == e_addr[i], "R3 read address", obs[i], e_addr[i]);
    @(negedge clk);
    chk(!done, "R9 done one cycle", 64'(done), 64'd0);
    chk(valid == ev && paddr == epa, "R9 result held", paddr, epa);
    if (busy_poke) begin
      repeat (12) @(negedge clk);
      chk(nobs == e_n, "R10 no walk from busy start", 64'(nobs), 64'(e_n));
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        lvl_pos = {6'd30, 6'd25, 6'd20, 6'd15, 6'd12};
        w[0] = 3;
        lvl_width = {5'd5, 5'd5, 5'd5, 5'd5, 5'd3};
        repeat (3) @(negedge clk);
        chk(!done && !mem_req_valid && !valid && !writable && paddr == 0,
            "R11 reset state", paddr, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_valid, "R11 idle no request", 64'(mem_req_valid), 64'd0);
        for (int m = 0; m < 16; m++) begin
          for (int s = 0; s < 8; s++) begin
            for (int h = 0; h < 2; h++) begin
              logic [63:0] va;
              seed = m * 97 + s * 13 + h + 1;
              lat = s % 4;
              for (int l = 1; l <= 4; l++) w[l] = m[l-1] ? 5 : 0;
              lvl_width = {5'(w[4]), 5'(w[3]), 5'(w[2]), 5'(w[1]), 5'(w[0])};
              root_hi = gen(64'hA5, seed);           // R1 high bits must be masked
              root_lo = gen(64'h5A, seed);
              va = gen(64'(m * 31 + s), seed + 7);
              va[63] = h[0];                         // R1 root select
              walk(va, (s == 3));                    // R10 start while busy
            end
          end
        end
      end
      begin
        for (wd = 0; wd < 150000; wd++) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule